// File: doc/BRIEF.md
# Register Block Word Mover

This block copies a run of consecutive general-purpose registers to memory, or fills them from memory, one 32-bit word per step. A single-cycle start pulse carries a direction, a first register index and a base byte address. The block then walks from the first index up to the highest register, issuing one word request per register on a valid/ready request channel. It waits for the matching response on a separate response channel before moving on. Only the first index sets the length of the run.

Loads write each returned word into the internal 32-entry register file. Stores take each outgoing word from that file. A second, independent read port gives combinational access to any register for inspection. The sequence is held by four named states. IDLE waits for a start pulse, and start moves it to ISSUE. ISSUE drives a request, and the request handshake moves it to AWAIT. AWAIT waits for the response. A response moves it back to ISSUE when registers remain, or to FINISH after the highest register. FINISH raises done for one cycle and returns to IDLE.

Top module: `regblk_mover`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_valid_o are all low.
- R2: A start pulse taken while idle makes busy_o high from the next cycle. busy_o stays high up to and including the done_o cycle, and is low in the cycle after.
- R3: A run beginning at index s performs exactly 32 - s word transfers, and the last one is register 31. s = 31 gives one transfer and s = 0 gives 32.
- R4: Transfer k (counting from 0) uses byte address base + 4*k, modulo 2^32.
- R5: start_store_i = 0 selects a load and 1 selects a store. mem_req_write_o is 0 on every request of a load run and 1 on every request of a store run.
- R6: In a load run, the data returned for transfer k is written to register s + k in the cycle its response is accepted. Registers below s keep their values.
- R7: In a store run, mem_req_wdata_o on transfer k equals the contents of register s + k.
- R8: Only one request is in flight at a time. After a request handshake, mem_req_valid_o stays low until the response has been accepted.
- R9: Start pulses that arrive while busy_o is high have no effect on the run in progress.
- R10: done_o is a one-cycle pulse. It rises in the cycle after the final response is accepted.
- R11: While mem_req_valid_o is high and mem_req_ready_i is low, the request stays valid and its address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| start_store_i | input | 1 | Direction for the run: 1 store, 0 load |
| start_idx_i | input | 5 | First register index of the run |
| base_addr_i | input | 32 | Byte address of the first word |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_valid_o | output | 1 | Request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_write_o | output | 1 | Request is a write |
| mem_req_addr_o | output | 32 | Request byte address |
| mem_req_wdata_o | output | 32 | Write data for a store request |
| mem_rsp_valid_i | input | 1 | Response valid: read data or write acknowledge |
| mem_rsp_rdata_i | input | 32 | Read data for a load response |
| dbg_idx_i | input | 5 | Inspection read index |
| dbg_data_o | output | 32 | Inspection read data |

## Verification
A wrong register index shows up at once as a wrong store data word on the request port. On a load it writes the wrong register, which the inspection port reveals after done. A wrong address counter shows in the very next request's address. A wrong state transition shows within a cycle or two: a second request before its response, a missing or doubled done pulse, or a run length other than 32 minus the first index. Stalls on the request handshake and response latencies from zero to three cycles check that the address and state hold while the block waits.

// File: rtl/regblk_pkg.sv
package regblk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_AWAIT  = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_t;

    typedef enum logic {
        DIR_LOAD  = 1'b0,
        DIR_STORE = 1'b1
    } xfer_dir_t;

endpackage

// File: rtl/regblk_rf.sv
module regblk_rf #(
    parameter int NREG   = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  ridx_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we && (widx == IDX_W'(g))) begin
                regs_q[g] <= wdata;
            end
        end
    end

    assign rdata_a = regs_q[ridx_a];
    assign rdata_b = regs_q[ridx_b];

endmodule

// File: rtl/regblk_fsm.sv
module regblk_fsm
    import regblk_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_store,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [ADDR_W-1:0] start_base,
    input  logic              req_ready,
    input  logic              rsp_valid,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              rf_we,
    output logic              busy,
    output logic              done
);

    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NREG - 1);
    localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(DATA_W / 8);

    seq_state_t state_q, state_d;
    xfer_dir_t  dir_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;

    wire take_start = (state_q == ST_IDLE) && start;
    wire req_fire   = (state_q == ST_ISSUE) && req_ready;
    wire rsp_fire   = (state_q == ST_AWAIT) && rsp_valid;
    wire last_step  = (idx_q == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take_start) state_d = ST_ISSUE;
            ST_ISSUE:  if (req_fire)   state_d = ST_AWAIT;
            ST_AWAIT:  if (rsp_fire)   state_d = last_step ? ST_FINISH : ST_ISSUE;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // run context: direction, register index, word address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= DIR_LOAD;
            idx_q  <= '0;
            addr_q <= '0;
        end else if (take_start) begin
            dir_q  <= start_store ? DIR_STORE : DIR_LOAD;
            idx_q  <= start_idx;
            addr_q <= start_base;
        end else if (rsp_fire && !last_step) begin
            idx_q  <= idx_q + 1'b1;
            addr_q <= addr_q + STRIDE;
        end
    end

    // outputs
    always_comb begin
        req_valid = (state_q == ST_ISSUE);
        req_write = (dir_q == DIR_STORE);
        req_addr  = addr_q;
        cur_idx   = idx_q;
        rf_we     = rsp_fire && (dir_q == DIR_LOAD);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
    end

    p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_last_then_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fire && cur_idx == LAST_IDX) |=> done);

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fire && !last_step) |=> (req_addr == $past(req_addr) + STRIDE));

endmodule

// File: rtl/regblk_mover.sv
module regblk_mover #(
    parameter int NREG   = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_store_i,
    input  logic [IDX_W-1:0]  start_idx_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic              mem_req_write_o,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    output logic [DATA_W-1:0] mem_req_wdata_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_rdata_i,
    input  logic [IDX_W-1:0]  dbg_idx_i,
    output logic [DATA_W-1:0] dbg_data_o
);

    logic [IDX_W-1:0] cur_idx;
    logic             rf_we;

    regblk_fsm #(
        .NREG   (NREG),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_i),
        .start_store (start_store_i),
        .start_idx   (start_idx_i),
        .start_base  (base_addr_i),
        .req_ready   (mem_req_ready_i),
        .rsp_valid   (mem_rsp_valid_i),
        .req_valid   (mem_req_valid_o),
        .req_write   (mem_req_write_o),
        .req_addr    (mem_req_addr_o),
        .cur_idx     (cur_idx),
        .rf_we       (rf_we),
        .busy        (busy_o),
        .done        (done_o)
    );

    regblk_rf #(
        .NREG   (NREG),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .widx    (cur_idx),
        .wdata   (mem_rsp_rdata_i),
        .ridx_a  (cur_idx),
        .rdata_a (mem_req_wdata_o),
        .ridx_b  (dbg_idx_i),
        .rdata_b (dbg_data_o)
    );

    p_write_only_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (!mem_req_write_o && mem_rsp_valid_i && busy_o));

endmodule

// File: tb/regblk_mover_tb.sv
`timescale 1ns/1ps
module regblk_mover_tb;

    localparam int NVEC = 7;
    // {store, start idx, base, ready stall, rsp latency, seed}
    localparam logic [59:0] VEC [NVEC] = '{
        {1'b0, 5'd0,  32'h0000_1000, 3'd0, 3'd0, 16'h1111},
        {1'b1, 5'd5,  32'h0000_2000, 3'd1, 3'd2, 16'h0000},
        {1'b0, 5'd31, 32'h0000_3FFC, 3'd2, 3'd0, 16'h2222},
        {1'b1, 5'd31, 32'h0000_4000, 3'd0, 3'd3, 16'h0000},
        {1'b0, 5'd20, 32'h8000_0100, 3'd3, 3'd1, 16'h3333},
        {1'b1, 5'd0,  32'h0000_5000, 3'd0, 3'd0, 16'h0000},
        {1'b0, 5'd16, 32'hFFFF_FFF0, 3'd0, 3'd1, 16'h4444}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        start_store_i = 1'b0;
    logic [4:0]  start_idx_i = '0;
    logic [31:0] base_addr_i = '0;
    logic        busy_o, done_o, mem_req_valid_o, mem_req_write_o;
    logic        mem_req_ready_i = 1'b0;
    logic [31:0] mem_req_addr_o, mem_req_wdata_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [31:0] mem_rsp_rdata_i = '0;
    logic [4:0]  dbg_idx_i = '0;
    logic [31:0] dbg_data_o;

    regblk_mover u_dut (.*);

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] shadow [32];
    bit          exp_store;
    int          exp_start;
    logic [31:0] exp_base;
    int          xfer_k;
    int          cur_stall, cur_lat;
    logic [15:0] cur_seed;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] gen(input logic [31:0] a, input logic [15:0] s);
        return (a * 32'h9E37_79B1) ^ {s, ~s};
    endfunction

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid_i = 1'b0;
            mem_req_ready_i = 1'b0;
            if (rst_n && mem_req_valid_o) begin
                repeat (cur_stall) @(negedge clk);
                mem_req_ready_i = 1'b1;
                chk(mem_req_addr_o == exp_base + 32'(4 * xfer_k), "R4 address",
                    mem_req_addr_o, exp_base + 32'(4 * xfer_k));
                chk(mem_req_write_o == exp_store, "R5 direction",
                    32'(mem_req_write_o), 32'(exp_store));
                chk(xfer_k < 32 - exp_start, "R3 too many transfers",
                    32'(xfer_k), 32'(32 - exp_start));
                if (exp_store && (exp_start + xfer_k) < 32)
                    chk(mem_req_wdata_o == shadow[exp_start + xfer_k], "R7 store data",
                        mem_req_wdata_o, shadow[exp_start + xfer_k]);
                @(negedge clk);
                mem_req_ready_i = 1'b0;
                chk(!mem_req_valid_o, "R8 request while outstanding",
                    32'(mem_req_valid_o), 32'd0);
                repeat (cur_lat) @(negedge clk);
                mem_rsp_valid_i = 1'b1;
                mem_rsp_rdata_i = gen(exp_base + 32'(4 * xfer_k), cur_seed);
                if (!exp_store && (exp_start + xfer_k) < 32)
                    shadow[exp_start + xfer_k] = mem_rsp_rdata_i;
                xfer_k++;
            end
        end
    end

    task automatic run(input bit st, input logic [4:0] idx, input logic [31:0] base,
                       input int stall, input int lat, input logic [15:0] seed, input bit ign);
        int waited;
        exp_store = st;
        exp_start = int'(idx);
        exp_base  = base;
        xfer_k    = 0;
        cur_stall = stall;
        cur_lat   = lat;
        cur_seed  = seed;
        @(negedge clk);
        start_i = 1'b1; start_store_i = st; start_idx_i = idx; base_addr_i = base;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R2 busy after start", 32'(busy_o), 32'd1);
        if (ign) begin
            repeat (2) @(negedge clk);
            start_i = 1'b1; start_store_i = ~st; start_idx_i = 5'd0; base_addr_i = 32'hDEAD_0000;
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_o && waited < 3000) begin
            chk(busy_o, "R2 busy during run", 32'(busy_o), 32'd1);
            @(negedge clk);
            waited++;
        end
        chk(done_o, "R10 done seen", 32'(done_o), 32'd1);
        chk(busy_o, "R2 busy with done", 32'(busy_o), 32'd1);
        chk(xfer_k == 32 - exp_start, ign ? "R9 run length kept" : "R3 transfer count",
            32'(xfer_k), 32'(32 - exp_start));
        @(negedge clk);
        chk(!done_o, "R10 done one cycle", 32'(done_o), 32'd0);
        chk(!busy_o, "R2 busy low after done", 32'(busy_o), 32'd0);
        chk(!mem_req_valid_o, "R9 no request after run", 32'(mem_req_valid_o), 32'd0);
        for (int r = 0; r < 32; r++) begin
            dbg_idx_i = 5'(r);
            #0.1;
            chk(dbg_data_o == shadow[r], "R6 register contents", dbg_data_o, shadow[r]);
        end
    endtask

    initial begin
        for (int r = 0; r < 32; r++) shadow[r] = '0;
        exp_store = 1'b0; exp_start = 0; exp_base = '0; xfer_k = 0;
        cur_stall = 0; cur_lat = 0; cur_seed = '0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !mem_req_valid_o, "R1 reset state",
            {29'd0, busy_o, done_o, mem_req_valid_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !mem_req_valid_o, "R1 idle after reset",
            {30'd0, busy_o, mem_req_valid_o}, 32'd0);
        // fill all registers first, so store data is known
        run(1'b0, 5'd0, 32'h0000_0800, 0, 0, 16'h0F0F, 1'b0);
        for (int v = 0; v < NVEC; v++) begin
            run(VEC[v][59], VEC[v][58:54], VEC[v][53:22], int'(VEC[v][21:19]),
                int'(VEC[v][18:16]), VEC[v][15:0], 1'b0);
        end
        // R9: start pulse mid-run is ignored
        run(1'b0, 5'd28, 32'h0000_6000, 1, 1, 16'h5555, 1'b1);
        // R3 corner: single-transfer store right after a load
        run(1'b1, 5'd31, 32'h0000_7000, 0, 0, 16'h0000, 1'b0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule